// File: doc/BRIEF.md
# Trigger Conditioning Unit

This block prepares eight logical triggers for a pattern generator/analyzer sequencer. The triggers are start, pause, four script triggers, reference and record advance. For each one, a source code in a configuration register picks the input to follow. The choices are an external pin, a backplane line, the pattern-comparator flag, a software strobe, or a "disabled" code that makes the trigger read as already satisfied.

A selected pin, backplane line or comparator input passes through a glitch filter with a programmable qualify count. The filtered value is then turned into a one-cycle edge pulse or a continuous level, according to the trigger's class and its two-bit mode field. One trigger can also be routed to an export output; the pause trigger can never be exported.

All inputs are assumed to be synchronous to the sample clock. The configuration is copied into an internal register only while the consumer reports that it is idle.

Top module: `trig_cond_unit`

## Requirements
- R1: Source codes are: 0 disabled, 1 software, 2 pattern match, 3 to 3+NP-1 external pins in index order, the next NB codes backplane lines in index order. Any higher code reads as a constant low input.
- R2: A trigger whose source code is 0 drives its output high on every cycle after the configuration takes effect, whatever its mode and whatever its inputs do.
- R3: With source code 1, the output is high for exactly the cycle after each cycle in which that trigger's software strobe bit is high. This path ignores the mode and the qualify count.
- R4: The pattern-match source follows the comparator input only for reference (index 6) and record advance (index 7). For every other trigger it reads as a constant low input.
- R5: With qualify count L, a change of the selected input is accepted only after it has been present for L+1 consecutive cycles. A pulse of W cycles with W ≤ L produces no output activity.
- R6: Trigger indices are start 0, pause 1, script 2..5, reference 6, advance 7. Mode bit 0 selects falling edge or active-low; mode bit 1 selects level or edge. Start, reference and advance are always edge-detected; their mode bit 1 has no effect.
- R7: Pause is always level-detected, active-high when mode bit 0 is 0 and active-low when it is 1; its mode bit 1 has no effect.
- R8: Each script trigger honours all four modes: 00 rising edge, 01 falling edge, 10 high level, 11 low level.
- R9: An edge-mode trigger outputs a single high cycle per accepted edge, two clock edges after the filter accepts the change. A level-mode trigger outputs the accepted level, with that same latency, for as long as the level holds.
- R10: When export is enabled, the export output is the selected trigger's output delayed by one cycle. It stays low when export is disabled or when the selected index is 1 (pause).
- R11: The configuration register loads from the configuration inputs only on cycles where the busy input is low. While busy is high, changes on those inputs have no effect.
- R12: Synchronous reset clears all outputs to 0. It also clears the configuration register to every source disabled, all modes 00, qualify count 0 and export off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| busy | input | 1 | Consumer running; blocks configuration loading |
| cfg_src | input | 8*SRC_W | Source code per trigger, trigger k in bits [k*SRC_W +: SRC_W] |
| cfg_mode | input | 16 | Mode per trigger, trigger k in bits [2k +: 2] |
| cfg_qual | input | QW | Glitch-filter qualify count L |
| cfg_exp_en | input | 1 | Export enable |
| cfg_exp_sel | input | 3 | Index of the trigger to export |
| pin_in | input | NP | External trigger pins |
| bp_in | input | NB | Backplane trigger lines |
| pm_in | input | 1 | Pattern-comparator match flag |
| sw_stb | input | 8 | Software strobe, one bit per trigger |
| trig_out | output | 8 | Conditioned trigger outputs |
| exp_out | output | 1 | Exported trigger |

## Verification
The bench builds the unit with two pins, two backplane lines and a three-bit qualify count, so the source code is only three bits wide. With these sizes, every trigger can be swept through all four mode codes, every qualify count from 0 to 3 and every pulse width from 1 to 4 cycles, which covers both sides of the filter threshold. Across that sweep the source code rotates over all pins and backplane lines. The expected count of active cycles and the expected index of the first active cycle are derived from the pulse width and the qualify count. Every export index is also tried, including the forbidden pause index.

// File: rtl/trig_cond_pkg.sv
package trig_cond_pkg;
  localparam int NUM_TRIG = 8;
  localparam int TIDX_W   = 3;

  // trigger indices (export select decodes these)
  localparam int TRG_START = 0;
  localparam int TRG_PAUSE = 1;
  localparam int TRG_SCR0  = 2;
  localparam int TRG_SCR3  = 5;
  localparam int TRG_REF   = 6;
  localparam int TRG_ADV   = 7;

  // fixed source codes; external lines follow from SRC_EXT0
  localparam int SRC_DIS  = 0;
  localparam int SRC_SW   = 1;
  localparam int SRC_PM   = 2;
  localparam int SRC_EXT0 = 3;

  // detection classes
  localparam int KIND_EDGE  = 0;
  localparam int KIND_LEVEL = 1;
  localparam int KIND_ANY   = 2;
endpackage

// File: rtl/trig_src_sel.sv
module trig_src_sel
  import trig_cond_pkg::*;
#(
  parameter int NP       = 4,
  parameter int NB       = 8,
  parameter int SRC_W    = 4,
  parameter bit ALLOW_PM = 1'b0
) (
  input  logic [SRC_W-1:0] src,
  input  logic [NP-1:0]    pin_in,
  input  logic [NB-1:0]    bp_in,
  input  logic             pm_in,
  output logic             raw,
  output logic             is_dis,
  output logic             is_sw
);
  localparam int BP0 = SRC_EXT0 + NP;

  always_comb begin
    is_dis = (src == SRC_W'(SRC_DIS));
    is_sw  = (src == SRC_W'(SRC_SW));
    raw    = 1'b0;
    if (src == SRC_W'(SRC_PM)) raw = ALLOW_PM ? pm_in : 1'b0;  // R4
    for (int k = 0; k < NP; k++)
      if (src == SRC_W'(SRC_EXT0 + k)) raw = pin_in[k];
    for (int k = 0; k < NB; k++)
      if (src == SRC_W'(BP0 + k)) raw = bp_in[k];
  end
endmodule

// File: rtl/trig_glitch_filt.sv
module trig_glitch_filt #(
  parameter int QW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          raw,
  input  logic [QW-1:0] qual,
  output logic          q
);
  logic [QW-1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      q       <= 1'b0;
      run_cnt <= '0;
    end else if (raw == q) begin
      run_cnt <= '0;
    end else if (run_cnt >= qual) begin
      q       <= raw;
      run_cnt <= '0;
    end else begin
      run_cnt <= run_cnt + 1'b1;
    end
  end

  // R5: the filtered value only ever moves to the value the input had
  assert_commit_follows_input_R5: assert property (@(posedge clk) disable iff (rst)
    !$stable(q) |-> ($past(raw) == q));
endmodule

// File: rtl/trig_detect.sv
module trig_detect
  import trig_cond_pkg::*;
#(
  parameter int NP       = 4,
  parameter int NB       = 8,
  parameter int SRC_W    = 4,
  parameter int QW       = 4,
  parameter int KIND     = KIND_ANY,
  parameter bit ALLOW_PM = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SRC_W-1:0] src,
  input  logic [1:0]       mode,
  input  logic [QW-1:0]    qual,
  input  logic [NP-1:0]    pin_in,
  input  logic [NB-1:0]    bp_in,
  input  logic             pm_in,
  input  logic             sw_stb,
  output logic             trig_out
);
  logic raw, is_dis, is_sw, filt_q, filt_d;
  logic edge_m, inv;

  trig_src_sel #(.NP(NP), .NB(NB), .SRC_W(SRC_W), .ALLOW_PM(ALLOW_PM)) u_sel (
    .src(src), .pin_in(pin_in), .bp_in(bp_in), .pm_in(pm_in),
    .raw(raw), .is_dis(is_dis), .is_sw(is_sw)
  );

  trig_glitch_filt #(.QW(QW)) u_filt (
    .clk(clk), .rst(rst), .raw(raw), .qual(qual), .q(filt_q)
  );

  // class decides which mode bits count (R6, R7, R8)
  always_comb begin
    inv = mode[0];
    case (KIND)
      KIND_EDGE:  edge_m = 1'b1;
      KIND_LEVEL: edge_m = 1'b0;
      default:    edge_m = ~mode[1];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      filt_d   <= 1'b0;
      trig_out <= 1'b0;
    end else begin
      filt_d <= filt_q;
      if (is_dis)      trig_out <= 1'b1;
      else if (is_sw)  trig_out <= sw_stb;
      else if (edge_m) trig_out <= inv ? (~filt_q & filt_d) : (filt_q & ~filt_d);
      else             trig_out <= filt_q ^ inv;
    end
  end

  // R2: a disabled source always reads as satisfied
  assert_disabled_reads_high_R2: assert property (@(posedge clk) disable iff (rst)
    is_dis |=> trig_out);
endmodule

// File: rtl/trig_cond_unit.sv
module trig_cond_unit
  import trig_cond_pkg::*;
#(
  parameter  int NP    = 4,
  parameter  int NB    = 8,
  parameter  int QW    = 4,
  localparam int SRC_W = $clog2(SRC_EXT0 + NP + NB + 1)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      busy,
  input  logic [NUM_TRIG*SRC_W-1:0] cfg_src,
  input  logic [NUM_TRIG*2-1:0]     cfg_mode,
  input  logic [QW-1:0]             cfg_qual,
  input  logic                      cfg_exp_en,
  input  logic [TIDX_W-1:0]         cfg_exp_sel,
  input  logic [NP-1:0]             pin_in,
  input  logic [NB-1:0]             bp_in,
  input  logic                      pm_in,
  input  logic [NUM_TRIG-1:0]       sw_stb,
  output logic [NUM_TRIG-1:0]       trig_out,
  output logic                      exp_out
);
  logic [NUM_TRIG*SRC_W-1:0] src_q;
  logic [NUM_TRIG*2-1:0]     mode_q;
  logic [QW-1:0]             qual_q;
  logic                      exp_en_q;
  logic [TIDX_W-1:0]         exp_sel_q;

  // R11: configuration captured only while idle; R12: cleared by reset
  always_ff @(posedge clk) begin
    if (rst) begin
      src_q     <= '0;
      mode_q    <= '0;
      qual_q    <= '0;
      exp_en_q  <= 1'b0;
      exp_sel_q <= '0;
    end else if (!busy) begin
      src_q     <= cfg_src;
      mode_q    <= cfg_mode;
      qual_q    <= cfg_qual;
      exp_en_q  <= cfg_exp_en;
      exp_sel_q <= cfg_exp_sel;
    end
  end

  for (genvar g = 0; g < NUM_TRIG; g++) begin : g_trig
    localparam int KIND = (g == TRG_PAUSE) ? KIND_LEVEL :
                          ((g >= TRG_SCR0 && g <= TRG_SCR3) ? KIND_ANY : KIND_EDGE);
    localparam bit PM_OK = (g == TRG_REF) || (g == TRG_ADV);

    trig_detect #(
      .NP(NP), .NB(NB), .SRC_W(SRC_W), .QW(QW), .KIND(KIND), .ALLOW_PM(PM_OK)
    ) u_det (
      .clk(clk), .rst(rst),
      .src(src_q[g*SRC_W +: SRC_W]),
      .mode(mode_q[g*2 +: 2]),
      .qual(qual_q),
      .pin_in(pin_in), .bp_in(bp_in), .pm_in(pm_in),
      .sw_stb(sw_stb[g]),
      .trig_out(trig_out[g])
    );
  end

  // export path; pause index is refused (R10)
  always_ff @(posedge clk) begin
    if (rst) exp_out <= 1'b0;
    else     exp_out <= exp_en_q && (exp_sel_q != TIDX_W'(TRG_PAUSE)) && trig_out[exp_sel_q];
  end

  assert_no_pause_export_R10: assert property (@(posedge clk) disable iff (rst)
    exp_out |-> ($past(exp_en_q) && ($past(exp_sel_q) != TIDX_W'(TRG_PAUSE))));

  assert_cfg_frozen_when_busy_R11: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(src_q) && $stable(mode_q) && $stable(qual_q)
              && $stable(exp_en_q) && $stable(exp_sel_q)));
endmodule

// File: tb/trig_cond_unit_tb.sv
`timescale 1ns/1ps
module trig_cond_unit_tb;
  localparam int NP = 2;
  localparam int NB = 2;
  localparam int QW = 3;
  localparam int SW = 3;          // source code width for these sizes
  localparam int NONE = 7;        // spare code: constant low

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic busy = 1'b1;
  logic [8*SW-1:0] cfg_src = '0;
  logic [15:0]     cfg_mode = '0;
  logic [QW-1:0]   cfg_qual = '0;
  logic            cfg_exp_en = 1'b0;
  logic [2:0]      cfg_exp_sel = '0;
  logic [NP-1:0]   pin_in = '0;
  logic [NB-1:0]   bp_in = '0;
  logic            pm_in = 1'b0;
  logic [7:0]      sw_stb = '0;
  logic [7:0]      trig_out;
  logic            exp_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  trig_cond_unit #(.NP(NP), .NB(NB), .QW(QW)) u_dut (
    .clk(clk), .rst(rst), .busy(busy),
    .cfg_src(cfg_src), .cfg_mode(cfg_mode), .cfg_qual(cfg_qual),
    .cfg_exp_en(cfg_exp_en), .cfg_exp_sel(cfg_exp_sel),
    .pin_in(pin_in), .bp_in(bp_in), .pm_in(pm_in), .sw_stb(sw_stb),
    .trig_out(trig_out), .exp_out(exp_out)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // dk 0: external code ln, dk 1: comparator, dk 2: software mask ln
  task automatic drive_set(input int dk, input int ln, input bit v);
    case (dk)
      0: if (ln < 3 + NP) pin_in[ln-3] = v; else bp_in[ln-3-NP] = v;
      1: pm_in = v;
      default: sw_stb = v ? 8'(ln) : 8'h00;
    endcase
  endtask

  // drive a W-cycle pulse from step 0, observe output obs (8 = export)
  task automatic run_window(input int dk, input int ln, input int w, input int obs,
                            input bit act_low, output int cnt, output int first);
    cnt = 0;
    first = -1;
    for (int j = 0; j <= 12; j++) begin
      if (j >= 1) begin
        bit v;
        v = (obs == 8) ? exp_out : trig_out[obs];
        if (v ^ act_low) begin
          cnt++;
          if (first < 0) first = j;
        end
      end
      drive_set(dk, ln, j < w);
      @(negedge clk);
    end
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int cnt, first;
    // R12: outputs low during reset; busy keeps the reset configuration
    cfg_src = {8{3'(NONE)}};
    repeat (3) @(negedge clk);
    chk(trig_out == 8'h00 && exp_out == 1'b0, "R12 reset outputs", int'(trig_out), 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(trig_out == 8'hFF, "R12 reset cfg all disabled", int'(trig_out), 255);
    busy = 1'b0;
    settle();
    chk(trig_out == 8'h00, "R1 spare code reads low", int'(trig_out), 0);

    // R2: disabled source, any mode, inputs toggling
    cfg_src = '0;
    cfg_mode = 16'hB4E1;
    settle();
    for (int c = 0; c < 10; c++) begin
      pin_in = 2'(c); bp_in = 2'(c + 1); pm_in = c[0]; sw_stb = 8'(c * 37);
      @(negedge clk);
      chk(trig_out == 8'hFF, "R2 disabled reads satisfied", int'(trig_out), 255);
    end
    pin_in = '0; bp_in = '0; pm_in = 1'b0; sw_stb = '0;

    // R1: backplane routing distinct from pins (trigger 2, level high)
    cfg_src = {8{3'(NONE)}};
    cfg_src[2*SW +: SW] = 3'd5;
    cfg_mode = '0;
    cfg_mode[5:4] = 2'b10;
    settle();
    pin_in = 2'b11; bp_in = 2'b10;
    settle();
    chk(trig_out[2] == 1'b0, "R1 other lines ignored", int'(trig_out[2]), 0);
    bp_in = 2'b01;
    settle();
    chk(trig_out[2] == 1'b1, "R1 selected backplane line", int'(trig_out[2]), 1);
    pin_in = '0; bp_in = '0;
    settle();

    // R5 R6 R7 R8 R9: sweep of trigger, mode, qualify count, width
    for (int i = 0; i < 8; i++)
      for (int m = 0; m < 4; m++)
        for (int l = 0; l < 4; l++)
          for (int w = 1; w <= 4; w++) begin
            bit is_edge, inv, act_low;
            int src, ecnt, efirst;
            string cls;
            src = 3 + ((i + l + w) % (NP + NB));
            inv = m[0];
            if (i == 1)            begin is_edge = 1'b0;  cls = "R7"; end
            else if (i >= 2 && i <= 5) begin is_edge = !m[1]; cls = "R8"; end
            else                   begin is_edge = 1'b1;  cls = "R6"; end
            act_low = !is_edge && inv;
            if (w <= l)       begin ecnt = 0; efirst = -1; end
            else if (is_edge) begin ecnt = 1; efirst = inv ? w + l + 2 : l + 2; end
            else              begin ecnt = w; efirst = l + 2; end
            cfg_src = {8{3'(NONE)}};
            cfg_src[i*SW +: SW] = 3'(src);
            cfg_mode = '0;
            cfg_mode[i*2 +: 2] = 2'(m);
            cfg_qual = 3'(l);
            settle();
            run_window(0, src, w, i, act_low, cnt, first);
            chk(cnt == ecnt, (w <= l) ? "R5 glitch filter" : cls, cnt, ecnt);
            chk(first == efirst, "R9 output timing", first, efirst);
          end

    // R3: software strobe, one cycle, independent of mode and filter
    cfg_qual = 3'd3;
    for (int i = 0; i < 8; i++) begin
      cfg_src = {8{3'(NONE)}};
      cfg_src[i*SW +: SW] = 3'd1;
      cfg_mode = '0;
      cfg_mode[i*2 +: 2] = 2'(i % 4);
      settle();
      run_window(2, 1 << i, 1, i, 1'b0, cnt, first);
      chk(cnt == 1, "R3 software pulse count", cnt, 1);
      chk(first == 1, "R3 software pulse timing", first, 1);
    end

    // R4: comparator only for reference and advance
    cfg_qual = '0;
    for (int i = 0; i < 8; i++) begin
      int ecnt;
      ecnt = (i >= 6) ? 1 : 0;
      cfg_src = {8{3'(NONE)}};
      cfg_src[i*SW +: SW] = 3'd2;
      cfg_mode = '0;
      settle();
      run_window(1, 0, 2, i, 1'b0, cnt, first);
      chk(cnt == ecnt, "R4 pattern match source", cnt, ecnt);
    end

    // R10: export of each index; pause refused; disabled export silent
    cfg_src = {8{3'd1}};
    cfg_mode = '0;
    for (int k = 0; k < 8; k++) begin
      int ecnt;
      ecnt = (k == 1) ? 0 : 1;
      cfg_exp_en = 1'b1;
      cfg_exp_sel = 3'(k);
      settle();
      run_window(2, 1 << k, 1, 8, 1'b0, cnt, first);
      chk(cnt == ecnt, "R10 export selected", cnt, ecnt);
      if (ecnt == 1) chk(first == 2, "R10 export timing", first, 2);
      run_window(2, 8'hFF ^ (1 << k), 1, 8, 1'b0, cnt, first);
      chk(cnt == 0, "R10 unselected not exported", cnt, 0);
      cfg_exp_en = 1'b0;
      settle();
      run_window(2, 1 << k, 1, 8, 1'b0, cnt, first);
      chk(cnt == 0, "R10 export disabled", cnt, 0);
    end

    // R11: configuration frozen while busy
    cfg_src = {8{3'(NONE)}};
    cfg_src[2:0] = 3'd3;
    cfg_mode = '0;
    cfg_qual = '0;
    settle();
    busy = 1'b1;
    cfg_src[2:0] = 3'd0;
    cfg_mode[1:0] = 2'b01;
    settle();
    chk(trig_out[0] == 1'b0, "R11 busy blocks disable", int'(trig_out[0]), 0);
    run_window(0, 3, 2, 0, 1'b0, cnt, first);
    chk(cnt == 1 && first == 2, "R11 old mode kept", first, 2);
    busy = 1'b0;
    settle();
    chk(trig_out[0] == 1'b1, "R11 load when idle", int'(trig_out[0]), 1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule